// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block widens a 12-bit immediate field from a data-processing instruction into the 32-bit constant that feeds the second ALU operand. It also produces the carry value that goes with that constant. There are two families of encoding. In the first, a single byte is either zero-extended or copied into a fixed set of byte lanes. In the second, an 8-bit value whose top bit is forced to one is rotated right by 8 to 31 positions.

The block is purely combinational and has no clock or reset. The decoder drives the immediate field, the current carry flag, and a strobe. The strobe says that the instruction is a flag-setting logical, move or test operation. From the block the datapath takes the constant, the carry-out, a write-enable for the carry flag and a flag marking encodings whose result is not defined.

Top module: `imm_expander`

## Requirements
- R1: When imm_i[11:10] = 00 and imm_i[9:8] = 00, const_o equals imm_i[7:0] zero-extended to 32 bits.
- R2: When imm_i[11:10] = 00 and imm_i[9:8] = 01, const_o = {8'h00, B, 8'h00, B}, where B = imm_i[7:0].
- R3: When imm_i[11:10] = 00 and imm_i[9:8] = 10, const_o = {B, 8'h00, B, 8'h00}.
- R4: When imm_i[11:10] = 00 and imm_i[9:8] = 11, const_o = {B, B, B, B}.
- R5: When imm_i[11:10] != 00, const_o is the 32-bit value {24'h0, 1'b1, imm_i[6:0]} rotated right by imm_i[11:7] positions.
- R6: carry_wr_o is 1 exactly when set_flags_i = 1 and imm_i[11:10] != 00. In that case carry_o equals const_o[31].
- R7: When carry_wr_o = 0, carry_o equals carry_i. This covers every byte or lane-pattern encoding and every encoding with set_flags_i = 0.
- R8: unpred_o is 1 exactly when imm_i[11:10] = 00, imm_i[9:8] != 00 and imm_i[7:0] = 0.
- R9: Every rotated-form constant is greater than 255 and has between one and eight bits set. Encoding 0x400 gives 0x80000000, and encoding 0xFFF gives 0x000001FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_i | input | 12 | Encoded immediate field |
| carry_i | input | 1 | Current carry flag |
| set_flags_i | input | 1 | Instruction is a flag-setting logical, move or test operation |
| const_o | output | 32 | Expanded second-operand constant |
| carry_o | output | 1 | Carry value to go with the constant |
| carry_wr_o | output | 1 | Carry flag is to be written with carry_o |
| unpred_o | output | 1 | Encoding has an undefined result |

## Verification
The bound checker tests a set of relations on every input change. Carry-out follows constant bit 31 whenever a carry write is signalled, and it follows the incoming flag otherwise. A write never happens without the flag-setting strobe. A rotated constant is always wider than a byte and holds at most eight set bits. The all-lanes pattern repeats its byte, and the undefined flag appears only for a zero byte in a lane pattern. None of these relations can show that the rotation amount is applied correctly, or that each lane pattern lands in the right lanes. Only the bench can show that, by sweeping all 4096 encodings with both carry values and both strobe values and comparing each output against values worked out arithmetically.

// File: rtl/imm_exp_pkg.sv
package imm_exp_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int IMM_W  = 12;

    typedef enum logic [1:0] {
        PAT_BYTE  = 2'b00,
        PAT_EVEN  = 2'b01,
        PAT_ODD   = 2'b10,
        PAT_ALL   = 2'b11
    } pat_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              carry_wr;
        logic              unpred;
    } exp_result_t;

endpackage

// File: rtl/imm_lane_pattern.sv
module imm_lane_pattern
    import imm_exp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic [BW-1:0] byte_i,
    input  pat_mode_e     mode_i,
    output logic [DW-1:0] word_o
);
    localparam int LANES = DW / BW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IS_EVEN = (i % 2) == 0;
        logic lane_en;
        always_comb begin
            case (mode_i)
                PAT_BYTE: lane_en = (i == 0);
                PAT_EVEN: lane_en = IS_EVEN;
                PAT_ODD:  lane_en = !IS_EVEN;
                default:  lane_en = 1'b1;
            endcase
        end
        assign word_o[i*BW +: BW] = lane_en ? byte_i : '0;
    end
endmodule

// File: rtl/imm_rotator.sv
module imm_rotator
    import imm_exp_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AMT_W = $clog2(DATA_W)
) (
    input  logic [DW-1:0]    data_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [DW-1:0]    data_o
);
    logic [DW-1:0] stage [0:AMT_W];

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {stage[s][SH-1:0], stage[s][DW-1:SH]}
            : stage[s];
    end

    assign data_o = stage[AMT_W];
endmodule

// File: rtl/imm_carry_sel.sv
module imm_carry_sel
    import imm_exp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] value_i,
    input  logic          rotated_i,
    input  logic          set_flags_i,
    input  logic          carry_i,
    output logic          carry_o,
    output logic          carry_wr_o
);
    always_comb begin
        carry_wr_o = rotated_i && set_flags_i;
        carry_o    = carry_wr_o ? value_i[DW-1] : carry_i;
    end
endmodule

// File: rtl/imm_expander.sv
module imm_expander
    import imm_exp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W,
    parameter int IW = IMM_W
) (
    input  logic [IW-1:0] imm_i,
    input  logic          carry_i,
    input  logic          set_flags_i,
    output logic [DW-1:0] const_o,
    output logic          carry_o,
    output logic          carry_wr_o,
    output logic          unpred_o
);
    localparam int AMT_W = IW - BW + 1;

    logic [BW-1:0]    byte_val;
    pat_mode_e        mode;
    logic             rotated;
    logic [AMT_W-1:0] rot_amt;
    logic [DW-1:0]    rot_src;
    logic [DW-1:0]    pat_word;
    logic [DW-1:0]    rot_word;
    logic [DW-1:0]    sel_word;
    logic             carry_sel;
    logic             carry_wr_sel;
    exp_result_t      res_d;

    assign byte_val = imm_i[BW-1:0];
    assign mode     = pat_mode_e'(imm_i[BW+1:BW]);
    assign rotated  = |imm_i[IW-1:BW+2];
    assign rot_amt  = imm_i[IW-1:BW-1];
    assign rot_src  = {{(DW-BW){1'b0}}, 1'b1, imm_i[BW-2:0]};

    imm_lane_pattern #(.DW(DW), .BW(BW)) u_pattern (
        .byte_i (byte_val),
        .mode_i (mode),
        .word_o (pat_word)
    );

    imm_rotator #(.DW(DW), .AMT_W(AMT_W)) u_rot (
        .data_i (rot_src),
        .amt_i  (rot_amt),
        .data_o (rot_word)
    );

    assign sel_word = rotated ? rot_word : pat_word;

    imm_carry_sel #(.DW(DW)) u_carry (
        .value_i     (sel_word),
        .rotated_i   (rotated),
        .set_flags_i (set_flags_i),
        .carry_i     (carry_i),
        .carry_o     (carry_sel),
        .carry_wr_o  (carry_wr_sel)
    );

    always_comb begin
        res_d          = '0;
        res_d.value    = sel_word;
        res_d.carry    = carry_sel;
        res_d.carry_wr = carry_wr_sel;
        res_d.unpred   = !rotated && (mode != PAT_BYTE) && (byte_val == '0);
    end

    assign const_o    = res_d.value;
    assign carry_o    = res_d.carry;
    assign carry_wr_o = res_d.carry_wr;
    assign unpred_o   = res_d.unpred;
endmodule

// File: rtl/imm_expander_chk.sv
module imm_expander_chk #(
    parameter int DW = 32,
    parameter int BW = 8,
    parameter int IW = 12
) (
    input logic [IW-1:0] imm_i,
    input logic          carry_i,
    input logic          set_flags_i,
    input logic [DW-1:0] const_o,
    input logic          carry_o,
    input logic          carry_wr_o,
    input logic          unpred_o
);
    logic known;
    logic rot_form;

    assign known    = !$isunknown({imm_i, carry_i, set_flags_i});
    assign rot_form = imm_i[IW-1:BW+2] != '0;

    always_comb begin
        if (known) begin
            AST_CARRY_BIT31: assert (!carry_wr_o || carry_o == const_o[DW-1]) else $error("carry"); // R6
            AST_WR_NEEDS_SET: assert (!carry_wr_o || (set_flags_i && rot_form)) else $error("wr"); // R6
            AST_CARRY_HOLD: assert (carry_wr_o || carry_o == carry_i) else $error("hold"); // R7
            AST_ROT_WIDE: assert (!rot_form || const_o > DW'(255)) else $error("wide"); // R9
            AST_ROT_POP: assert (!rot_form || ($countones(const_o) >= 1 && $countones(const_o) <= BW)) else $error("pop"); // R9
            AST_ALL_REPEAT: assert (rot_form || imm_i[BW+1:BW] != 2'b11 || const_o[DW-1 -: BW] == const_o[BW-1:0]) else $error("rep"); // R4
            AST_UNPRED_ZERO: assert (!unpred_o || (!rot_form && imm_i[BW-1:0] == '0)) else $error("unpred"); // R8
        end
    end
endmodule

bind imm_expander imm_expander_chk #(.DW(DW), .BW(BW), .IW(IW)) u_chk (.*);

// File: tb/imm_expander_tb.sv
module imm_expander_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] imm_i = '0;
    logic        carry_i = 1'b0;
    logic        set_flags_i = 1'b0;
    logic [31:0] const_o;
    logic        carry_o;
    logic        carry_wr_o;
    logic        unpred_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    imm_expander u_dut (
        .imm_i       (imm_i),
        .carry_i     (carry_i),
        .set_flags_i (set_flags_i),
        .const_o     (const_o),
        .carry_o     (carry_o),
        .carry_wr_o  (carry_wr_o),
        .unpred_o    (unpred_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s imm=%03h c=%0b s=%0b actual=%08h expected=%08h",
                     tag, imm_i, carry_i, set_flags_i, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_const(input logic [11:0] e);
        logic [31:0] b;
        logic [63:0] dbl;
        b = {24'h0, e[7:0]};
        if (e[11:10] != 2'b00) begin
            dbl = {24'h0, 1'b1, e[6:0], 24'h0, 1'b1, e[6:0]};
            return dbl[31:0] >> 0 == 0 ? 32'h0 : 32'(dbl >> e[11:7]);
        end
        case (e[9:8])
            2'b00:   return b;
            2'b01:   return b * 32'h0001_0001;
            2'b10:   return b * 32'h0100_0100;
            default: return b * 32'h0101_0101;
        endcase
    endfunction

    task automatic apply(input logic [11:0] e, input logic c, input logic s);
        @(posedge clk);
        imm_i = e; carry_i = c; set_flags_i = s;
        @(negedge clk);
    endtask

    task automatic sweep_one(input logic [11:0] e, input logic c, input logic s);
        logic [31:0] exp_v;
        logic        rot;
        logic        exp_wr;
        string       vtag;
        apply(e, c, s);
        exp_v  = ref_const(e);
        rot    = e[11:10] != 2'b00;
        exp_wr = rot && s;
        if (rot) vtag = "R5";
        else case (e[9:8])
            2'b00:   vtag = "R1";
            2'b01:   vtag = "R2";
            2'b10:   vtag = "R3";
            default: vtag = "R4";
        endcase
        chk(vtag, const_o, exp_v);
        chk("R6 carry_wr", {31'h0, carry_wr_o}, {31'h0, exp_wr});
        if (exp_wr) chk("R6 carry", {31'h0, carry_o}, {31'h0, exp_v[31]});
        else        chk("R7 carry", {31'h0, carry_o}, {31'h0, c});
        chk("R8 unpred", {31'h0, unpred_o},
            {31'h0, !rot && e[9:8] != 2'b00 && e[7:0] == 8'h00});
        if (rot) chk("R9 wide", {31'h0, exp_v > 32'd255 && const_o > 32'd255}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        apply(12'h000, 1'b0, 1'b0);
        chk("R1 idle", const_o, 32'h0);
        chk("R7 idle", {29'h0, carry_o, carry_wr_o, unpred_o}, 32'h0);
        apply(12'h400, 1'b0, 1'b1);
        chk("R9 min rot", const_o, 32'h8000_0000);
        chk("R6 min rot carry", {31'h0, carry_o}, 32'h1);
        apply(12'hFFF, 1'b1, 1'b1);
        chk("R9 max rot", const_o, 32'h0000_01FE);
        chk("R6 max rot carry", {31'h0, carry_o}, 32'h0);
        apply(12'h3A5, 1'b1, 1'b1);
        chk("R4 fixed", const_o, 32'hA5A5_A5A5);
        chk("R7 pattern hold", {30'h0, carry_o, carry_wr_o}, 32'h2);
        apply(12'h1C3, 1'b0, 1'b0);
        chk("R2 fixed", const_o, 32'h00C3_00C3);
        apply(12'h27E, 1'b0, 1'b0);
        chk("R3 fixed", const_o, 32'h7E00_7E00);
        apply(12'h200, 1'b0, 1'b0);
        chk("R8 zero byte", {31'h0, unpred_o}, 32'h1);
        for (int e = 0; e < 4096; e++) begin
            for (int m = 0; m < 4; m++) begin
                sweep_one(12'(e), m[0], m[1]);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule